// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Controller

This block produces the external pin timing of one machine cycle for a small 8-bit processor whose low address byte and data byte share the same eight lines. A request gives a cycle kind, a 16-bit address and, for writes, a data byte. The controller walks through T-states, each of which is split into two halves. It drives the high address byte, the shared lines and their output enable, the address latch strobe, the read and write strobes, and three status lines. For reads it captures the returned byte and holds it. It raises a one-cycle done pulse in the final half-state.

The block runs on a clock at twice the T-state rate, so each half T-state lasts one clock. A request is taken only when the controller is idle and the kind code is legal. Any other request is dropped without effect. An opcode fetch takes four T-states, which is eight clocks. Every other kind takes three T-states, which is six clocks.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: During and after reset the controller is idle. Idle means ale_o=0, rd_n_o=1, wr_n_o=1, ad_oe_o=0, done_o=0, io_m_o=s1_o=s0_o=0, addr_hi_o=0 and rdata_o=0.
- R2: Kind codes on kind_i are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. An opcode fetch lasts 8 clocks and the other kinds last 6 clocks, counted from the clock after the accepting edge. done_o is high only in the last of those clocks.
- R3: addr_hi_o carries address bits 15:8 for the whole cycle. In both halves of T1, ad_o carries address bits 7:0 with ad_oe_o=1.
- R4: ale_o is high only in the first half of T1.
- R5: For kinds 0, 1 and 3, rd_n_o is low from the start of T2 through the first half of T3. It is high at all other times.
- R6: For kinds 2 and 4, wr_n_o is low from the start of T2 through the first half of T3. ad_o carries the write byte with ad_oe_o=1 through T2 and T3.
- R7: For read kinds, ad_oe_o is low after T1. The byte on ad_i in the first half of T3 is captured into rdata_o and held until the next read.
- R8: Status {io_m_o,s1_o,s0_o} is 011 for opcode fetch, 010 for memory read, 001 for memory write, 110 for I/O read and 101 for I/O write. It holds that value for the whole cycle.
- R9: In T4 of an opcode fetch, ale_o=0, rd_n_o=1, wr_n_o=1 and ad_oe_o=0.
- R10: A request made while a cycle is running, or made with a kind code of 5 to 7, is ignored. Outputs and cycle length are unchanged, and no cycle follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the T-state rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request |
| kind_i | input | 3 | Cycle kind code |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write byte |
| ad_i | input | 8 | Shared lines, inbound value |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Shared lines, outbound value |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | Status: I/O (1) or memory (0) |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
All pin outputs are decoded from registered state. Half-state n of a cycle is therefore the n-th clock after the accepting edge, and the bench compares every pin in that clock at the falling edge. The read byte is captured at the edge that ends the first half of T3, so it is first checked at the final half-state. The device model places a wrong byte on ad_i during T2 and the correct byte from T3 onward, which exposes an early capture. After each cycle, one falling edge is checked for the idle state, and this shows that a request made mid-cycle or with an illegal kind produced no extra cycle.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;
  typedef enum logic [2:0] {
    CYC_OPF  = 3'd0,
    CYC_MRD  = 3'd1,
    CYC_MWR  = 3'd2,
    CYC_IORD = 3'd3,
    CYC_IOWR = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } cyc_stat_t;

  function automatic logic kind_legal(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_rd(cyc_kind_e k);
    return (k == CYC_OPF) || (k == CYC_MRD) || (k == CYC_IORD);
  endfunction

  function automatic logic kind_wr(cyc_kind_e k);
    return (k == CYC_MWR) || (k == CYC_IOWR);
  endfunction

  function automatic cyc_stat_t kind_stat(cyc_kind_e k);
    cyc_stat_t s;
    case (k)
      CYC_OPF:  s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      CYC_MRD:  s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      CYC_MWR:  s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      CYC_IORD: s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      CYC_IOWR: s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bus_tstate_seq.sv
module bus_tstate_seq #(
  parameter int unsigned TS_W   = 2,
  parameter int unsigned N_LONG = 4,
  parameter int unsigned N_SHRT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            long_i,
  output logic            active_o,
  output logic [TS_W-1:0] tstate_o,
  output logic            phase_o,
  output logic            last_o
);
  localparam logic [TS_W-1:0] LAST_LONG = TS_W'(N_LONG - 1);
  localparam logic [TS_W-1:0] LAST_SHRT = TS_W'(N_SHRT - 1);

  logic            active_q, phase_q, long_q;
  logic [TS_W-1:0] ts_q;
  logic            at_last_ts;

  assign at_last_ts = ts_q == (long_q ? LAST_LONG : LAST_SHRT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      long_q   <= 1'b0;
      ts_q     <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        long_q   <= long_i;
        ts_q     <= '0;
      end
    end else if (!phase_q) begin
      phase_q <= 1'b1;
    end else begin
      phase_q <= 1'b0;
      if (at_last_ts) active_q <= 1'b0;
      else            ts_q     <= ts_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign tstate_o = ts_q;
  assign phase_o  = phase_q;
  assign last_o   = active_q && phase_q && at_last_ts;

  // R2
  last_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !active_o);
  // R2
  half_pairs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !phase_o) |=> (active_o && phase_o));
endmodule

// File: rtl/bus_pin_drv.sv
module bus_pin_drv
  import bus_cyc_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned TS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [TS_W-1:0] tstate_i,
  input  logic            phase_i,
  input  cyc_kind_e       kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   ad_i,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            ale_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output cyc_stat_t       stat_o,
  output logic [DW-1:0]   rdata_o
);
  localparam logic [TS_W-1:0] TS1 = TS_W'(0);
  localparam logic [TS_W-1:0] TS2 = TS_W'(1);
  localparam logic [TS_W-1:0] TS3 = TS_W'(2);

  logic in_t1, in_t2, in_t3, strobe_win, is_rd, is_wr;
  logic [DW-1:0] rdata_q;

  assign in_t1 = active_i && (tstate_i == TS1);
  assign in_t2 = active_i && (tstate_i == TS2);
  assign in_t3 = active_i && (tstate_i == TS3);
  assign is_rd = kind_rd(kind_i);
  assign is_wr = kind_wr(kind_i);
  // strobes span T2 and the first half of T3
  assign strobe_win = in_t2 || (in_t3 && !phase_i);

  always_comb begin
    addr_hi_o = active_i ? addr_i[AW-1:DW] : '0;
    ale_o     = in_t1 && !phase_i;
    rd_n_o    = !(is_rd && strobe_win);
    wr_n_o    = !(is_wr && strobe_win);
    stat_o    = active_i ? kind_stat(kind_i) : '0;
    ad_oe_o   = in_t1 || (is_wr && (in_t2 || in_t3));
    if (in_t1)        ad_o = addr_i[DW-1:0];
    else if (ad_oe_o) ad_o = wdata_i;
    else              ad_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          rdata_q <= '0;
    else if (is_rd && in_t3 && !phase_i)  rdata_q <= ad_i;
  end
  assign rdata_o = rdata_q;

  // R5
  no_rd_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  // R7
  no_drive_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ad_oe_o && !rd_n_o));
  // R4
  ale_single_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> !ale_o);
  // R5
  rd_after_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_n_o) |-> $past(ale_o, 2));
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cyc_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned TS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [2:0]      kind_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   ad_i,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic            ale_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic            io_m_o,
  output logic            s1_o,
  output logic            s0_o,
  output logic [DW-1:0]   rdata_o,
  output logic            done_o
);
  logic            active, phase, last, accept;
  logic [TS_W-1:0] tstate;
  cyc_kind_e       kind_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  cyc_stat_t       stat;

  assign accept = req_i && !active && kind_legal(kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CYC_OPF;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= cyc_kind_e'(kind_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  bus_tstate_seq #(.TS_W(TS_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .long_i   (kind_i == CYC_OPF),
    .active_o (active),
    .tstate_o (tstate),
    .phase_o  (phase),
    .last_o   (last)
  );

  bus_pin_drv #(.AW(AW), .DW(DW), .TS_W(TS_W)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .tstate_i  (tstate),
    .phase_i   (phase),
    .kind_i    (kind_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .ad_i      (ad_i),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .stat_o    (stat),
    .rdata_o   (rdata_o)
  );

  assign io_m_o = stat.io_m;
  assign s1_o   = stat.s1;
  assign s0_o   = stat.s0;
  assign done_o = last;

  // checker: half-states elapsed since accept
  logic [3:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (accept) len_q <= '0;
    else if (active) len_q <= len_q + 1'b1;
  end

  // R2
  cycle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_q == ((kind_q == CYC_OPF) ? 4'd7 : 4'd5)));
  // R8
  stat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !ale_o) |-> $stable({io_m_o, s1_o, s0_o}));
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_n_o && wr_n_o && !ale_o));
  // R10
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!ale_o && !ad_oe_o && !done_o));
endmodule

// File: tb/bus_cycle_ctrl_tb.sv
module bus_cycle_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  ad_in = '0;
  logic [7:0]  addr_hi, ad_out, rdata;
  logic        ad_oe, ale, rd_n, wr_n, io_m, s1, s0, done;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bus_cycle_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .wdata_i(wdata), .ad_i(ad_in), .addr_hi_o(addr_hi), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .io_m_o(io_m), .s1_o(s1), .s0_o(s0), .rdata_o(rdata), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, 32'(ale), 0);
    chk({tag, " rd_n"}, 32'(rd_n), 1);
    chk({tag, " wr_n"}, 32'(wr_n), 1);
    chk({tag, " oe"}, 32'(ad_oe), 0);
    chk({tag, " done"}, 32'(done), 0);
    chk({tag, " status"}, 32'({io_m, s1, s0}), 0);
    chk({tag, " addr_hi"}, 32'(addr_hi), 0);
  endtask

  function automatic logic [2:0] exp_stat(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  // start at a falling edge with the block idle; poke = request mid-cycle
  task automatic run_cyc(input logic [2:0] k, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] rb, input bit poke);
    int n;
    bit rdk, wrk;
    n   = (k == 3'd0) ? 8 : 6;
    rdk = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    wrk = (k == 3'd2) || (k == 3'd4);
    req = 1'b1; kind = k; addr = a; wdata = wd; ad_in = 8'h00;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ad_in = (i >= 4) ? rb : ~rb;
      if (poke && i == 2) begin
        req = 1'b1; kind = 3'd2; addr = 16'hffff; wdata = 8'h00;
      end else begin
        req = 1'b0;
      end
      chk("R4 ale", 32'(ale), 32'(i == 0));
      chk("R5 rd_n", 32'(rd_n), 32'(!(rdk && i >= 2 && i <= 4)));
      chk("R6 wr_n", 32'(wr_n), 32'(!(wrk && i >= 2 && i <= 4)));
      chk("R3 R7 oe", 32'(ad_oe), 32'(i < 2 || (wrk && i < 6)));
      if (i < 2)             chk("R3 ad_lo", 32'(ad_out), 32'(a[7:0]));
      else if (wrk && i < 6) chk("R6 ad_wdata", 32'(ad_out), 32'(wd));
      chk("R3 addr_hi", 32'(addr_hi), 32'(a[15:8]));
      chk("R8 status", 32'({io_m, s1, s0}), 32'(exp_stat(k)));
      chk("R2 done", 32'(done), 32'(i == n - 1));
      if (i >= 6)
        chk("R9 t4 quiet", 32'({ale, rd_n, wr_n, ad_oe}), 32'(4'b0110));
      if (rdk && i == n - 1) chk("R7 rdata", 32'(rdata), 32'(rb));
      @(negedge clk);
    end
    req = 1'b0;
    chk_idle(poke ? "R10 after busy req" : "R2 idle after");
  endtask

  task automatic t_reset();
    chk_idle("R1 in reset");
    chk("R1 rdata", 32'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");
  endtask

  task automatic t_illegal();
    for (int k = 5; k < 8; k++) begin
      req = 1'b1; kind = 3'(k); addr = 16'h1234;
      @(negedge clk);
      req = 1'b0;
      chk_idle("R10 illegal kind");
      @(negedge clk);
      chk_idle("R10 illegal kind later");
    end
  endtask

  task automatic t_hold_rdata();
    run_cyc(3'd2, 16'h0102, 8'h99, 8'h00, 1'b0);
    chk("R7 rdata held over write", 32'(rdata), 32'h3c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    run_cyc(3'd0, 16'h2000, 8'h00, 8'h06, 1'b0);
    run_cyc(3'd1, 16'h2001, 8'h00, 8'h43, 1'b0);
    run_cyc(3'd2, 16'h526a, 8'ha5, 8'h00, 1'b0);
    run_cyc(3'd3, 16'h00f3, 8'h00, 8'h3c, 1'b0);
    t_hold_rdata();
    run_cyc(3'd4, 16'hff10, 8'h5e, 8'h00, 1'b0);
    run_cyc(3'd0, 16'hbeef, 8'h00, 8'hc3, 1'b1);
    run_cyc(3'd3, 16'h0044, 8'h00, 8'h81, 1'b1);
    t_illegal();
    run_cyc(3'd1, 16'h8001, 8'h00, 8'hff, 1'b0);
    summary();
  end
endmodule